// File: doc/BRIEF.md
# Radix-2 decimation-in-frequency feedback-delay FFT stage

This block is one pipeline stage of a streaming radix-2 decimation-in-frequency FFT. It accepts one complex sample per accepted beat and emits one complex sample per accepted beat. Each group of `2*DEPTH` accepted samples forms a block. The stage pairs sample `k` with sample `k+DEPTH` through a feedback shift register that is `DEPTH` entries deep. It emits their sum first. Later it emits their difference, rotated by the twiddle factor for index `k`. With `DEPTH = 16` the stage acts as the first stage of a 32-point transform.

A counter advances on every accepted input beat and selects one of three phases:
- **Fill**: the first half-block after reset. Samples are only stored.
- **Sum**: the second half of every block. The stage emits the sum of the stored sample and the incoming sample, and stores their difference.
- **Rotate**: the first half of every later block. The stage emits the stored difference times the twiddle factor, and stores the incoming sample.

The complex product uses three real multipliers and five adders.

Both ends of the stage are valid/ready streams. A beat transfers on a rising clock edge when valid and ready are both high. The input is ready whenever the output register is empty or is being drained in the same cycle. Once the output presents a beat, it holds that beat unchanged until the beat is taken. The stage produces no output on its own. The rotated differences of the last block come out only when a further `DEPTH` samples are pushed in, so upstream flushes the stage with zeros.

Top module: `sdf_r2_stage`

## Requirements
- R1: A synchronous active-high `rst` clears the phase counter, the delay line and `out_valid`. In the cycle after reset, `out_valid` is 0 and `in_ready` is 1, and a fresh stream is processed from block position 0.
- R2: After reset, the first `DEPTH` accepted samples produce no output. `out_valid` first rises on the edge that accepts sample number `DEPTH+1`.
- R3: For a block `x[0..2*DEPTH-1]` of accepted samples, the stage emits `x[k]+x[k+DEPTH]` for k = 0..DEPTH-1, in order of k. Each value appears in the cycle after `x[k+DEPTH]` is accepted.
- R4: While the first `DEPTH` samples of the following block are accepted, the stage emits `(x[k]-x[k+DEPTH])·T[k]` in order of k, within 1 LSB per component.
  - T[k] = C + jS, where C = round(cos(πk/DEPTH)·2^(W-1)) and S = −round(sin(πk/DEPTH)·2^(W-1)). Each magnitude is limited to 2^(W-1)−1.
  - Each product component is rounded by adding 2^(W-2) and shifting arithmetically right by W−1.
- R5: Input components are `IN_W`-bit two's complement, sign-extended to `W` bits before use. Sums are not saturated, so input extremes (−32768, 32767) give exact results such as −65536.
- R6: With `in_valid` and `out_ready` held high, `out_valid` stays high continuously from its first rise for as long as samples keep arriving.
- R7: `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, `out_re`/`out_im` hold their values and no input is taken.
- R8: Cycles without `in_valid` do not advance the stage and do not change any result. When a held output is taken and no new input is accepted in that cycle, `out_valid` falls.
- R9: The rotated differences of the last block appear only as `DEPTH` further samples are accepted. Without accepted input, no further output appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Stage can take an input sample this cycle |
| in_re | input | IN_W | Input real part, two's complement |
| in_im | input | IN_W | Input imaginary part, two's complement |
| out_valid | output | 1 | Output sample present |
| out_ready | input | 1 | Downstream takes the output sample this cycle |
| out_re | output | W | Output real part, two's complement |
| out_im | output | W | Output imaginary part, two's complement |

## Verification
The bench builds the stage with `DEPTH = 16`, `IN_W = 16` and `W = 24`, the configuration of the first stage of a 32-point transform. This size covers every twiddle entry, including the saturated cosine at k = 0 and the saturated sine at k = 8. It also brings sign-extension and growth tests at full 16-bit input range within reach, and the counter wraps across several consecutive blocks. Input gaps and output stalls are driven from a pseudo-random sequence, so phase changes land both inside and outside stalled cycles.

// File: rtl/sdf_pkg.sv
package sdf_pkg;

  typedef enum logic [1:0] {
    PH_FILL = 2'd0,
    PH_SUM  = 2'd1,
    PH_ROT  = 2'd2
  } phase_e;

  localparam real PI = 3.14159265358979323846;

  // Power series, used only to build constants at elaboration.
  function automatic real sin_series(input real x);
    real term;
    real acc;
    term = x;
    acc  = x;
    for (int n = 1; n < 30; n++) begin
      term = -term * x * x / (real'(2 * n) * real'(2 * n + 1));
      acc  = acc + term;
    end
    return acc;
  endfunction

  function automatic real cos_series(input real x);
    real term;
    real acc;
    term = 1.0;
    acc  = 1.0;
    for (int n = 1; n < 30; n++) begin
      term = -term * x * x / (real'(2 * n - 1) * real'(2 * n));
      acc  = acc + term;
    end
    return acc;
  endfunction

  // Scale to fixed point with frac fractional bits, limit magnitude below one.
  function automatic longint to_fixed(input real v, input int frac);
    longint lim;
    longint r;
    lim = (longint'(1) << frac) - 1;
    r   = longint'(v * (2.0 ** frac));
    if (r > lim)  r = lim;
    if (r < -lim) r = -lim;
    return r;
  endfunction

endpackage

// File: rtl/sdf_delay_line.sv
module sdf_delay_line #(
  parameter int DEPTH = 16,
  parameter int W     = 24
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                shift,
  input  logic signed [W-1:0] d_re,
  input  logic signed [W-1:0] d_im,
  output logic signed [W-1:0] q_re,
  output logic signed [W-1:0] q_im
);

  for (genvar i = 0; i < DEPTH; i++) begin : g_tap
    logic signed [W-1:0] r_re;
    logic signed [W-1:0] r_im;
    if (i == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (rst) begin
          r_re <= '0;
          r_im <= '0;
        end else if (shift) begin
          r_re <= d_re;
          r_im <= d_im;
        end
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (rst) begin
          r_re <= '0;
          r_im <= '0;
        end else if (shift) begin
          r_re <= g_tap[i-1].r_re;
          r_im <= g_tap[i-1].r_im;
        end
      end
    end
  end

  assign q_re = g_tap[DEPTH-1].r_re;
  assign q_im = g_tap[DEPTH-1].r_im;

endmodule

// File: rtl/sdf_ctrl.sv
module sdf_ctrl
  import sdf_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  output phase_e        phase,
  output logic [AW-1:0] tw_idx
);

  logic [CW-1:0] cnt;
  logic          primed;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      primed <= 1'b0;
    end else if (adv) begin
      cnt <= cnt + 1'b1;
      if (cnt[CW-1]) primed <= 1'b1;
    end
  end

  always_comb begin
    if (cnt[CW-1])   phase = PH_SUM;
    else if (primed) phase = PH_ROT;
    else             phase = PH_FILL;
  end

  assign tw_idx = cnt[AW-1:0];

endmodule

// File: rtl/sdf_twiddle_rom.sv
module sdf_twiddle_rom
  import sdf_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int W     = 24,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic [AW-1:0]       idx,
  output logic signed [W-1:0] c_re,
  output logic signed [W-1:0] c_im
);

  logic signed [W-1:0] tab_re [DEPTH];
  logic signed [W-1:0] tab_im [DEPTH];

  for (genvar k = 0; k < DEPTH; k++) begin : g_ent
    localparam real    ANG  = PI * real'(k) / real'(DEPTH);
    localparam longint V_RE = to_fixed(cos_series(ANG), W - 1);
    localparam longint V_IM = -to_fixed(sin_series(ANG), W - 1);
    assign tab_re[k] = V_RE[W-1:0];
    assign tab_im[k] = V_IM[W-1:0];
  end

  assign c_re = tab_re[idx];
  assign c_im = tab_im[idx];

endmodule

// File: rtl/sdf_cmul3.sv
module sdf_cmul3 #(
  parameter int W   = 24,
  localparam int PW = 2 * W + 2
) (
  input  logic signed [W-1:0] a,
  input  logic signed [W-1:0] b,
  input  logic signed [W-1:0] c,
  input  logic signed [W-1:0] d,
  output logic signed [W-1:0] p_re,
  output logic signed [W-1:0] p_im
);

  localparam logic signed [PW-1:0] HALF = PW'(longint'(1) << (W - 2));

  logic signed [W:0]    s_ab, s_dc, s_cd;
  logic signed [PW-1:0] k1, k2, k3, f_re, f_im;

  always_comb begin
    s_ab = (W+1)'(a) + (W+1)'(b);
    s_dc = (W+1)'(d) - (W+1)'(c);
    s_cd = (W+1)'(c) + (W+1)'(d);
    k1   = PW'(c) * PW'(s_ab);
    k2   = PW'(a) * PW'(s_dc);
    k3   = PW'(b) * PW'(s_cd);
    f_re = k1 - k3;
    f_im = k1 + k2;
  end

  assign p_re = W'((f_re + HALF) >>> (W - 1));
  assign p_im = W'((f_im + HALF) >>> (W - 1));

endmodule

// File: rtl/sdf_r2_stage.sv
module sdf_r2_stage
  import sdf_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int IN_W  = 16,
  parameter int W     = 24,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic signed [IN_W-1:0] in_re,
  input  logic signed [IN_W-1:0] in_im,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic signed [W-1:0]    out_re,
  output logic signed [W-1:0]    out_im
);

  if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
    $error("DEPTH must be a power of two, at least 2");
  end

  phase_e              phase;
  logic [AW-1:0]       tw_idx;
  logic                adv;
  logic signed [W-1:0] x_re, x_im, dl_re, dl_im, tw_re, tw_im;
  logic signed [W-1:0] rot_re, rot_im, push_re, push_im;

  assign in_ready = !out_valid || out_ready;
  assign adv      = in_valid && in_ready;
  assign x_re     = W'(in_re);
  assign x_im     = W'(in_im);

  sdf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst(rst), .adv(adv), .phase(phase), .tw_idx(tw_idx)
  );

  sdf_twiddle_rom #(.DEPTH(DEPTH), .W(W)) u_rom (
    .idx(tw_idx), .c_re(tw_re), .c_im(tw_im)
  );

  sdf_delay_line #(.DEPTH(DEPTH), .W(W)) u_dly (
    .clk(clk), .rst(rst), .shift(adv),
    .d_re(push_re), .d_im(push_im), .q_re(dl_re), .q_im(dl_im)
  );

  sdf_cmul3 #(.W(W)) u_mul (
    .a(dl_re), .b(dl_im), .c(tw_re), .d(tw_im), .p_re(rot_re), .p_im(rot_im)
  );

  // Sum phase stores the difference; the other phases store the new sample.
  always_comb begin
    if (phase == PH_SUM) begin
      push_re = dl_re - x_re;
      push_im = dl_im - x_im;
    end else begin
      push_re = x_re;
      push_im = x_im;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_re    <= '0;
      out_im    <= '0;
    end else if (adv) begin
      out_valid <= (phase != PH_FILL);
      if (phase == PH_SUM) begin
        out_re <= dl_re + x_re;
        out_im <= dl_im + x_im;
      end else if (phase == PH_ROT) begin
        out_re <= rot_re;
        out_im <= rot_im;
      end
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/sdf_r2_stage_chk.sv
module sdf_r2_stage_chk #(
  parameter int DEPTH = 16,
  parameter int IN_W  = 16,
  parameter int W     = 24
) (
  input logic                clk,
  input logic                rst,
  input logic                in_valid,
  input logic                in_ready,
  input logic                out_valid,
  input logic                out_ready,
  input logic signed [W-1:0] out_re,
  input logic signed [W-1:0] out_im
);

  logic [31:0] n_in;

  always_ff @(posedge clk) begin
    if (rst)                                       n_in <= '0;
    else if (in_valid && in_ready && n_in != '1)   n_in <= n_in + 1'b1;
  end

  p_reset_clear_r1: assert property (@(posedge clk) rst |=> !out_valid);

  p_fill_silent_r2: assert property (@(posedge clk) disable iff (rst)
    (n_in <= 32'(DEPTH)) |-> !out_valid);

  p_stream_on_r6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && in_valid) |=> out_valid);

  p_hold_stall_r7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_re) && $stable(out_im)));

  p_drop_taken_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(out_valid) |-> ($past(out_ready) || $past(rst)));

  p_idle_empty_r9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && !in_valid) |=> !out_valid);

endmodule

bind sdf_r2_stage sdf_r2_stage_chk #(.DEPTH(DEPTH), .IN_W(IN_W), .W(W)) u_chk (.*);

// File: tb/sim_sdf_r2_stage.sv
`timescale 1ns/1ps
module sim_sdf_r2_stage;
  localparam int D = 16, IN_W = 16, W = 24, N = 2 * D;
  localparam longint ONE = longint'(1) << (W - 1);
  // rows: pattern, amplitude, mode (bit0 input gaps, bit1 output stalls)
  localparam int TBL [8][3] = '{
    '{0, 12000, 0}, '{1, 20000, 0}, '{2, 900, 1}, '{3, 0, 0},
    '{4, 0, 2},     '{5, 30000, 3}, '{4, 0, 3},   '{1, -32768, 1}
  };

  logic clk = 0, rst = 1, in_valid = 0, out_ready = 1;
  logic in_ready, out_valid;
  logic signed [IN_W-1:0] in_re = '0, in_im = '0;
  logic signed [W-1:0] out_re, out_im;
  always #4 clk = ~clk;

  sdf_r2_stage #(.DEPTH(D), .IN_W(IN_W), .W(W)) u0 (.*);

  int n_cmp = 0, n_bad = 0;
  int s_re[$], s_im[$], s_mode[$];
  longint e_re[$], e_im[$];
  int e_tol[$];
  string e_req[$];
  logic [15:0] lf = 16'hACE1;

  function automatic logic [15:0] lfsr_next(input logic [15:0] v);
    return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
  endfunction

  function automatic longint fixq(input real v);
    longint r;
    r = longint'($floor(v * real'(ONE) + 0.5));
    if (r > ONE - 1) r = ONE - 1;
    if (r < -(ONE - 1)) r = -(ONE - 1);
    return r;
  endfunction

  task automatic check(input string req, input longint act, input longint exp, input int tol);
    n_cmp++;
    if (act > exp + tol || act < exp - tol) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_q();
    s_re.delete(); s_im.delete(); s_mode.delete();
    e_re.delete(); e_im.delete(); e_tol.delete(); e_req.delete();
  endtask

  task automatic do_reset();
    rst = 1; in_valid = 0; out_ready = 1;
    repeat (3) @(negedge clk);
    rst = 0;
  endtask

  // One block of 2*D samples plus its expected sums and rotated differences.
  task automatic gen_block(input int pat, input int amp, input int mode, input bit last);
    int xr[N], xi[N];
    string rs, rd;
    for (int i = 0; i < N; i++) begin
      case (pat)
        0: begin xr[i] = (i == 0) ? amp : 0; xi[i] = (i == D + 3) ? amp / 2 : 0; end
        1: begin xr[i] = amp; xi[i] = amp / 2; end
        2: begin xr[i] = amp * (i - 16); xi[i] = amp * (15 - i); end
        3: begin xr[i] = i[0] ? -32768 : 32767; xi[i] = -32768; end
        4: begin
          lf = lfsr_next(lf); xr[i] = int'($signed(lf));
          lf = lfsr_next(lf); xi[i] = int'($signed(lf));
        end
        default: begin
          xr[i] = $rtoi(amp * $cos(2.0 * 3.14159265358979 * 3.0 * i / N));
          xi[i] = -$rtoi(amp * $sin(2.0 * 3.14159265358979 * 3.0 * i / N));
        end
      endcase
      s_re.push_back(xr[i]); s_im.push_back(xi[i]); s_mode.push_back(mode);
    end
    rs = (mode & 1) ? "R8" : (pat == 3) ? "R5" : "R3";
    rd = last ? "R9" : (mode & 1) ? "R8" : "R4";
    for (int k = 0; k < D; k++) begin
      e_re.push_back(xr[k] + xr[k+D]); e_im.push_back(xi[k] + xi[k+D]);
      e_tol.push_back(0); e_req.push_back(rs);
    end
    for (int k = 0; k < D; k++) begin
      longint a, b, c, d;
      a = xr[k] - xr[k+D]; b = xi[k] - xi[k+D];
      c = fixq($cos(3.14159265358979323846 * k / D));
      d = -fixq($sin(3.14159265358979323846 * k / D));
      e_re.push_back((a * c - b * d + (ONE >>> 1)) >>> (W - 1));
      e_im.push_back((a * d + b * c + (ONE >>> 1)) >>> (W - 1));
      e_tol.push_back(1); e_req.push_back(rd);
    end
  endtask

  task automatic add_flush();
    for (int i = 0; i < D; i++) begin s_re.push_back(0); s_im.push_back(0); s_mode.push_back(0); end
  endtask

  task automatic run_stream(input bit cont);
    int idx = 0, cyc = 0, acc = 0, mode;
    bit held = 0, seen = 0;
    logic signed [W-1:0] hr = '0, hi = '0;
    while (!(idx == s_re.size() && e_re.size() == 0)) begin
      @(negedge clk);
      cyc++;
      if (cyc > 20000) begin check("watchdog", 0, 1, 0); break; end
      mode = (idx < s_re.size()) ? s_mode[idx] : 0;
      lf = lfsr_next(lf);
      out_ready = !((mode & 2) != 0 && lf[3]);
      in_valid = (idx < s_re.size()) && !((mode & 1) != 0 && lf[7]);
      if (in_valid) begin in_re = IN_W'(s_re[idx]); in_im = IN_W'(s_im[idx]); end
      #1;
      if (held) begin // R7 stalled output unchanged
        check("R7", out_valid, 1, 0);
        check("R7", out_re, hr, 0);
        check("R7", out_im, hi, 0);
      end
      held = out_valid && !out_ready;
      if (held) begin hr = out_re; hi = out_im; check("R7", in_ready, 0, 0); end
      if (out_valid && !seen) check("R2", acc, D + 1, 0);
      if (cont && seen && idx < s_re.size()) check("R6", out_valid, 1, 0);
      if (out_valid) seen = 1;
      if (out_valid && out_ready) begin
        if (e_re.size() == 0) check("R9", 1, 0, 0);
        else begin
          check(e_req[0], out_re, e_re[0], e_tol[0]);
          check(e_req[0], out_im, e_im[0], e_tol[0]);
          void'(e_re.pop_front()); void'(e_im.pop_front());
          void'(e_tol.pop_front()); void'(e_req.pop_front());
        end
      end
      if (in_valid && in_ready) begin idx++; acc++; end
    end
    in_valid = 0; out_ready = 1;
    repeat (3) begin @(negedge clk); #1; check("R9", out_valid, 0, 0); end
  endtask

  initial begin
    do_reset();
    #1;
    check("R1", out_valid, 0, 0);
    check("R1", in_ready, 1, 0);

    // Table of stimulus rows, one continuous stream.
    clear_q();
    foreach (TBL[r]) gen_block(TBL[r][0], TBL[r][1], TBL[r][2], r == 7);
    add_flush();
    run_stream(0);

    // Directed: continuous valid with no gaps or stalls (R6).
    do_reset();
    clear_q();
    gen_block(2, 700, 0, 0); gen_block(4, 0, 0, 0); gen_block(5, 25000, 0, 1);
    add_flush();
    run_stream(1);

    // Directed: reset in mid-block, then a fresh block must align (R1).
    do_reset();
    for (int i = 0; i < D + 3; i++) begin
      @(negedge clk); in_valid = 1; out_ready = 1;
      in_re = IN_W'(100 + i); in_im = IN_W'(-7 * i);
    end
    @(negedge clk); in_valid = 0; rst = 1;
    @(negedge clk); #1;
    check("R1", out_valid, 0, 0);
    check("R1", in_ready, 1, 0);
    rst = 0;
    clear_q();
    gen_block(4, 0, 0, 1);
    add_flush();
    run_stream(0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(8 * 190000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule